// File: doc/BRIEF.md
# Per-Sample Ring Buffer Address Generator

This block produces word addresses for a sample-rate signal processor that works on a circular region of a shared memory. A hidden down-counter steps back by one on every sample strobe and wraps inside the ring size that is currently programmed. Each memory access names one of 32 pointer registers. In relative mode the counter is added to that pointer, so a fixed pointer walks through the ring one word per sample. In absolute mode the pointer alone is used. Both results are folded into the ring and then placed on top of a programmable ring base.

A host writes the pointers, the ring base and the ring size through a small register port at any time, including while accesses are in flight. The base can therefore be switched between two rings in one cycle with no pause of the sample stream. The host cannot read the counter back. It can only infer the counter from the addresses the block produces.

Top module: `ring_addr_gen`

## Requirements
- R1: After reset `acc_valid` is 0, the counter is 0, and the base, all pointers and the size code are 0. A relative access to pointer 0 made before any strobe therefore yields address 0.
- R2: Each cycle with `sample_tick` high lowers the counter by exactly one. Cycles without the strobe leave it unchanged.
- R3: The size code s (3 bits) selects a ring of 2^(13+s) words, from 8K at code 0 to 1M at code 7. Every offset is masked with ring size minus 1, and the counter wraps from 0 to ring size minus 1.
- R4: An absolute access (`acc_rel`=0) yields base + (pointer AND mask). The sample strobe has no effect on it.
- R5: A relative access (`acc_rel`=1) yields base + ((pointer + counter) AND mask), taken modulo 2^24.
- R6: The 32 pointers are independent. `acc_ptr` selects which pointer an access uses.
- R7: A base write takes effect for an access requested in the following cycle. An access requested in the same cycle as the write uses the previous base.
- R8: A pointer write takes effect for an access requested in the following cycle. An access requested in the same cycle as the write uses the previous pointer value.
- R9: `acc_valid` goes high for exactly one cycle, in the cycle after each request. `acc_addr` holds the result during that cycle.
- R10: Host register map on `hw_addr` (6 bits): 0–31 write the pointers (the low 20 bits of `hw_data`), 32 writes the base (24 bits), and 33 writes the size code (bits 2:0). Writes to 34–63 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle strobe per audio sample |
| acc_req | input | 1 | Access request |
| acc_ptr | input | 5 | Pointer index for the access |
| acc_rel | input | 1 | 1 = counter-relative, 0 = absolute |
| hw_en | input | 1 | Host write enable |
| hw_addr | input | 6 | Host register select |
| hw_data | input | 24 | Host write data |
| acc_valid | output | 1 | Address valid, one cycle after request |
| acc_addr | output | 24 | Generated word address |

## Verification
The assertions check three things on every cycle. They check the request-to-valid timing of the access state machine. They check that every produced address lies inside the ring above the base that was in force at the request. They also check that absolute addresses match the selected pointer and that the counter holds between strobes. The bench's scenarios are needed for the rest. These are the exact decrement and wrap points at several ring sizes, the same-cycle write ordering of base and pointers, and the independence of the 32 pointers. They also cover the silence of unmapped host addresses, which shows only through later addresses.

// File: rtl/ring_addr_pkg.sv
package ring_addr_pkg;

    localparam int RAG_OFS_W   = 20;  // widest ring offset (1M words)
    localparam int RAG_MIN_LOG = 13;  // log2 of smallest ring (8K words)
    localparam int RAG_SEL_W   = 3;   // ring size code width
    localparam int RAG_AW      = 24;  // memory word address width
    localparam int RAG_NPTR    = 32;  // pointer register count

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_PTR,
        TGT_BASE,
        TGT_SIZE
    } host_tgt_t;

    typedef enum logic {
        ACC_IDLE,
        ACC_OUT
    } acc_state_t;

endpackage

// File: rtl/ring_host_regs.sv
module ring_host_regs
    import ring_addr_pkg::*;
#(
    parameter int OFS_W   = RAG_OFS_W,
    parameter int MIN_LOG = RAG_MIN_LOG,
    parameter int SEL_W   = RAG_SEL_W,
    parameter int AW      = RAG_AW,
    parameter int NPTR    = RAG_NPTR,
    localparam int PIDX_W = $clog2(NPTR),
    localparam int HA_W   = PIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic [HA_W-1:0]   hw_addr,
    input  logic [AW-1:0]     hw_data,
    input  logic [PIDX_W-1:0] rd_idx,
    output logic [OFS_W-1:0]  rd_ptr,
    output logic [AW-1:0]     base_q,
    output logic [OFS_W-1:0]  ring_mask
);

    host_tgt_t               tgt;
    logic [SEL_W-1:0]        size_q;
    logic [OFS_W-1:0]        ptr_q [NPTR];
    logic [OFS_W:0]          ring_words;
    logic                    unused_hi;

    assign unused_hi = ^hw_data[AW-1:OFS_W];

    // Decode the host address into a write target.
    always_comb begin
        tgt = TGT_NONE;
        if (hw_en) begin
            if (!hw_addr[HA_W-1]) begin
                tgt = TGT_PTR;
            end else if (hw_addr[PIDX_W-1:0] == PIDX_W'(0)) begin
                tgt = TGT_BASE;
            end else if (hw_addr[PIDX_W-1:0] == PIDX_W'(1)) begin
                tgt = TGT_SIZE;
            end
        end
    end

    // Pointer file, one register per slot.
    generate
        for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ptr_q[gi] <= '0;
                end else if (tgt == TGT_PTR && hw_addr[PIDX_W-1:0] == PIDX_W'(gi)) begin
                    ptr_q[gi] <= hw_data[OFS_W-1:0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
        end else begin
            unique case (tgt)
                TGT_BASE: base_q <= hw_data;
                TGT_SIZE: size_q <= hw_data[SEL_W-1:0];
                TGT_PTR,
                TGT_NONE: ;
            endcase
        end
    end

    // Ring size is a power of two; the mask is size minus one.
    assign ring_words = (OFS_W+1)'(1) << (MIN_LOG + int'(size_q));
    assign ring_mask  = ring_words[OFS_W-1:0] - OFS_W'(1);

    assign rd_ptr = ptr_q[rd_idx];

endmodule

// File: rtl/ring_offset_counter.sv
module ring_offset_counter
    import ring_addr_pkg::*;
#(
    parameter int OFS_W = RAG_OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic [OFS_W-1:0] ring_mask,
    output logic [OFS_W-1:0] cnt_q
);

    logic [OFS_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (sample_tick) begin
            cnt_d = (cnt_q - OFS_W'(1)) & ring_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ring_addr_calc.sv
module ring_addr_calc
    import ring_addr_pkg::*;
#(
    parameter int OFS_W = RAG_OFS_W,
    parameter int AW    = RAG_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req,
    input  logic             acc_rel,
    input  logic [OFS_W-1:0] ptr_val,
    input  logic [OFS_W-1:0] cnt_val,
    input  logic [OFS_W-1:0] ring_mask,
    input  logic [AW-1:0]    base_val,
    output logic             acc_valid,
    output logic [AW-1:0]    acc_addr
);

    acc_state_t       state_q;
    acc_state_t       state_d;
    logic [OFS_W-1:0] ofs_c;
    logic [AW-1:0]    addr_c;
    logic [AW-1:0]    addr_q;

    always_comb begin
        ofs_c  = acc_rel ? ((ptr_val + cnt_val) & ring_mask) : (ptr_val & ring_mask);
        addr_c = base_val + {{(AW-OFS_W){1'b0}}, ofs_c};
    end

    // Next state: ACC_IDLE -> ACC_OUT on a request; ACC_OUT -> ACC_OUT on a
    // back-to-back request, otherwise back to ACC_IDLE.
    always_comb begin
        unique case (state_q)
            ACC_IDLE: state_d = acc_req ? ACC_OUT : ACC_IDLE;
            ACC_OUT:  state_d = acc_req ? ACC_OUT : ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (acc_req) begin
                addr_q <= addr_c;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ACC_IDLE: acc_valid = 1'b0;
            ACC_OUT:  acc_valid = 1'b1;
        endcase
        acc_addr = addr_q;
    end

endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
    import ring_addr_pkg::*;
#(
    parameter int OFS_W   = RAG_OFS_W,
    parameter int MIN_LOG = RAG_MIN_LOG,
    parameter int SEL_W   = RAG_SEL_W,
    parameter int AW      = RAG_AW,
    parameter int NPTR    = RAG_NPTR,
    localparam int PIDX_W = $clog2(NPTR),
    localparam int HA_W   = PIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              acc_req,
    input  logic [PIDX_W-1:0] acc_ptr,
    input  logic              acc_rel,
    input  logic              hw_en,
    input  logic [HA_W-1:0]   hw_addr,
    input  logic [AW-1:0]     hw_data,
    output logic              acc_valid,
    output logic [AW-1:0]     acc_addr
);

    logic [OFS_W-1:0] sel_ptr;
    logic [OFS_W-1:0] cnt_q;
    logic [OFS_W-1:0] ring_mask;
    logic [AW-1:0]    base_q;

    ring_host_regs #(
        .OFS_W(OFS_W), .MIN_LOG(MIN_LOG), .SEL_W(SEL_W), .AW(AW), .NPTR(NPTR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data),
        .rd_idx(acc_ptr), .rd_ptr(sel_ptr),
        .base_q(base_q), .ring_mask(ring_mask)
    );

    ring_offset_counter #(.OFS_W(OFS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .sample_tick(sample_tick), .ring_mask(ring_mask), .cnt_q(cnt_q)
    );

    ring_addr_calc #(.OFS_W(OFS_W), .AW(AW)) u_calc (
        .clk(clk), .rst_n(rst_n),
        .acc_req(acc_req), .acc_rel(acc_rel),
        .ptr_val(sel_ptr), .cnt_val(cnt_q), .ring_mask(ring_mask),
        .base_val(base_q),
        .acc_valid(acc_valid), .acc_addr(acc_addr)
    );

endmodule

// File: rtl/ring_addr_gen_chk.sv
module ring_addr_gen_chk #(
    parameter int OFS_W = 20,
    parameter int AW    = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_tick,
    input logic             acc_req,
    input logic             acc_rel,
    input logic             acc_valid,
    input logic [AW-1:0]    acc_addr,
    input logic [AW-1:0]    base_q,
    input logic [OFS_W-1:0] ring_mask,
    input logic [OFS_W-1:0] cnt_q,
    input logic [OFS_W-1:0] sel_ptr
);

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> acc_valid); // R9

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> !acc_valid); // R9

    AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(cnt_q)); // R2

    AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> (((acc_addr - $past(base_q)) & ~{{(AW-OFS_W){1'b0}}, $past(ring_mask)}) == '0)); // R3

    AST_ABS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_rel) |=>
            acc_addr == $past(base_q) + {{(AW-OFS_W){1'b0}}, ($past(sel_ptr) & $past(ring_mask))}); // R4

endmodule

bind ring_addr_gen ring_addr_gen_chk #(.OFS_W(OFS_W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .acc_req(acc_req), .acc_rel(acc_rel),
    .acc_valid(acc_valid), .acc_addr(acc_addr),
    .base_q(base_q), .ring_mask(ring_mask), .cnt_q(cnt_q), .sel_ptr(sel_ptr)
);

// File: tb/ring_addr_gen_bench.sv
module ring_addr_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_BASE  = 32;
    localparam int ADDR_SIZE  = 33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_tick = 1'b0;
    logic        acc_req = 1'b0;
    logic [4:0]  acc_ptr = '0;
    logic        acc_rel = 1'b0;
    logic        hw_en = 1'b0;
    logic [5:0]  hw_addr = '0;
    logic [23:0] hw_data = '0;
    logic        acc_valid;
    logic [23:0] acc_addr;

    int n_chk = 0;
    int n_fail = 0;

    // Requirement model kept by the bench.
    int unsigned cnt_m = 0;
    int unsigned mask_m = 32'h1FFF;
    int unsigned base_m = 0;
    int unsigned ptr_m [32];

    ring_addr_gen u_ring_addr_gen (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
        .acc_req(acc_req), .acc_ptr(acc_ptr), .acc_rel(acc_rel),
        .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data),
        .acc_valid(acc_valid), .acc_addr(acc_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int unsigned expect_addr(input int idx, input bit rel);
        int unsigned ofs;
        ofs = rel ? ((ptr_m[idx] + cnt_m) & mask_m) : (ptr_m[idx] & mask_m);
        return (base_m + ofs) & 32'hFF_FFFF;
    endfunction

    task automatic host_wr(input int a, input int unsigned d);
        @(negedge clk);
        hw_en = 1'b1; hw_addr = 6'(a); hw_data = 24'(d);
        @(negedge clk);
        hw_en = 1'b0;
        if (a < 32) ptr_m[a] = d & 32'hF_FFFF;
        else if (a == ADDR_BASE) base_m = d & 32'hFF_FFFF;
        else if (a == ADDR_SIZE) mask_m = (32'h1 << (13 + (d & 7))) - 1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sample_tick = 1'b1;
            @(negedge clk); sample_tick = 1'b0;
            cnt_m = (cnt_m - 1) & mask_m;
        end
    endtask

    // Request at a falling edge, sample at the next one; then confirm the pulse ends.
    task automatic access_chk(input string req, input int idx, input bit rel);
        int unsigned exp;
        exp = expect_addr(idx, rel);
        @(negedge clk);
        acc_req = 1'b1; acc_ptr = 5'(idx); acc_rel = rel;
        @(negedge clk);
        acc_req = 1'b0;
        check("R9 valid high", 32'(acc_valid), 1);
        check(req, 32'(acc_addr), exp);
        @(negedge clk);
        check("R9 valid one cycle", 32'(acc_valid), 0);
    endtask

    task automatic t_reset;
        check("R1 valid at reset", 32'(acc_valid), 0);
        access_chk("R1 rel ptr0 after reset", 0, 1'b1);
        access_chk("R1 abs ptr0 after reset", 0, 1'b0);
    endtask

    task automatic t_decrement;
        host_wr(3, 100);
        access_chk("R5 rel no tick", 3, 1'b1);
        ticks(5);
        check("R2 model", cnt_m, 32'h1FFB);
        access_chk("R2 rel after 5 ticks", 3, 1'b1);
        check("R2 value", 32'(acc_addr), 95 - 5 + 5);
        ticks(1);
        access_chk("R2 rel after 6 ticks", 3, 1'b1);
    endtask

    task automatic t_wrap;
        host_wr(ADDR_SIZE, 0);
        host_wr(4, 32'h1FFE);
        access_chk("R3 rel wrap 8K", 4, 1'b1);
        host_wr(ADDR_SIZE, 3);
        host_wr(4, 32'hFFFFF);
        access_chk("R3 rel mask 64K", 4, 1'b1);
        ticks(3);
        access_chk("R3 rel after ticks 64K", 4, 1'b1);
        host_wr(ADDR_SIZE, 7);
        access_chk("R3 abs 1M", 4, 1'b0);
    endtask

    task automatic t_absolute;
        host_wr(ADDR_BASE, 32'h10_0000);
        host_wr(7, 32'h12345);
        access_chk("R4 abs before ticks", 7, 1'b0);
        check("R4 abs value", 32'(acc_addr), 32'h11_2345);
        ticks(3);
        access_chk("R4 abs after ticks", 7, 1'b0);
        check("R4 abs unchanged", 32'(acc_addr), 32'h11_2345);
    endtask

    task automatic t_pointers;
        for (int i = 0; i < 32; i++) host_wr(i, i * 3571 + 11);
        for (int i = 0; i < 32; i++) access_chk("R6 pointer select abs", i, 1'b0);
        access_chk("R6 pointer select rel", 17, 1'b1);
    endtask

    task automatic t_base_live;
        host_wr(ADDR_BASE, 32'hA0_0000);
        access_chk("R7 base next cycle", 5, 1'b1);
        @(negedge clk);
        hw_en = 1'b1; hw_addr = 6'(ADDR_BASE); hw_data = 24'h30_0000;
        acc_req = 1'b1; acc_ptr = 5'd5; acc_rel = 1'b0;
        @(negedge clk);
        hw_en = 1'b0; acc_req = 1'b0;
        check("R7 same-cycle old base", 32'(acc_addr), expect_addr(5, 1'b0));
        base_m = 32'h30_0000;
        access_chk("R7 new base", 5, 1'b0);
    endtask

    task automatic t_ptr_same_cycle;
        @(negedge clk);
        hw_en = 1'b1; hw_addr = 6'd9; hw_data = 24'h0_4321;
        acc_req = 1'b1; acc_ptr = 5'd9; acc_rel = 1'b0;
        @(negedge clk);
        hw_en = 1'b0; acc_req = 1'b0;
        check("R8 same-cycle old pointer", 32'(acc_addr), expect_addr(9, 1'b0));
        ptr_m[9] = 32'h4321;
        access_chk("R8 new pointer", 9, 1'b0);
    endtask

    task automatic t_unmapped;
        for (int a = 34; a < 64; a += 5) begin
            @(negedge clk);
            hw_en = 1'b1; hw_addr = 6'(a); hw_data = 24'hFF_FFFF;
            @(negedge clk);
            hw_en = 1'b0;
        end
        access_chk("R10 unmapped keeps ptr0", 0, 1'b0);
        access_chk("R10 unmapped keeps ptr31", 31, 1'b0);
        access_chk("R10 unmapped keeps mask/base", 12, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) ptr_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decrement();
        t_wrap();
        t_absolute();
        t_pointers();
        t_base_live();
        t_ptr_same_cycle();
        t_unmapped();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule